// File: doc/BRIEF.md
# Half-Rate Command Slot Serializer

This block sits between a memory-controller scheduler that runs at half the DRAM clock rate and the DRAM command/address pins. In every core cycle the scheduler offers two command slots. Each slot has a valid flag, a three-bit command code, a bank and an address. The serializer drives both slots onto the command bus within that same core cycle, one per DRAM clock. A row activate and a column access can therefore leave together, and the slower core clock costs no command bandwidth.

The design runs in a single DRAM-clock domain. A toggle register stands in for the core clock, and its phase is brought out as `load_phase_o`. While that output is high, the next rising edge captures both slots. The slot inputs are ignored on the other edge. Slot 0 always goes out before slot 1. A slot whose valid flag is low becomes a NOP. The asynchronous reset is released through a small synchronizer, so phase alignment after reset is fixed.

Top module: `hrcs_serializer`

## Requirements
- R1: While `rst_n` is low, and until the first rising edge after the internal reset release, the bus shows a deselect: `ca_cs_n`=1, `ca_ras_n`=`ca_cas_n`=`ca_we_n`=1, and bank and address zero.
- R2: `load_phase_o` is high during reset. It is still high in the clock period that follows the second rising edge after `rst_n` rises. After that it alternates on every rising edge.
- R3: Slot 0 is captured at a rising edge where `load_phase_o` is high. It is on the bus after the next rising edge.
- R4: Slot 1 of the same capture is on the bus after the second rising edge following the capture, directly behind slot 0.
- R5: For a valid slot the bus carries `ca_cs_n`=0, `ca_ras_n`=code bit 2, `ca_cas_n`=code bit 1, `ca_we_n`=code bit 0, with bank and address unchanged. For example, activate is 011, read is 101, write is 100 and precharge is 010.
- R6: A slot whose valid flag is low goes out as a NOP: `ca_cs_n`=0, the three command strobes high, and bank and address zero.
- R7: Slot inputs present at a rising edge where `load_phase_o` is low have no effect on the bus.
- R8: Core cycles offered back to back come out as an unbroken stream. Every DRAM clock carries exactly one slot, in offer order.
- R9: A reset in the middle of a stream discards every captured slot. After release, the first words on the bus are NOPs until new slots arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_vld | input | 1 | Slot 0 carries a command |
| s0_cmd | input | 3 | Slot 0 command code {ras_n, cas_n, we_n} |
| s0_bank | input | BA_W | Slot 0 bank |
| s0_addr | input | ADDR_W | Slot 0 address |
| s1_vld | input | 1 | Slot 1 carries a command |
| s1_cmd | input | 3 | Slot 1 command code {ras_n, cas_n, we_n} |
| s1_bank | input | BA_W | Slot 1 bank |
| s1_addr | input | ADDR_W | Slot 1 address |
| load_phase_o | output | 1 | High when the next rising edge captures both slots |
| ca_cs_n | output | 1 | Chip select, active low |
| ca_ras_n | output | 1 | Row strobe, active low |
| ca_cas_n | output | 1 | Column strobe, active low |
| ca_we_n | output | 1 | Write enable, active low |
| ca_bank | output | BA_W | Bank on the bus |
| ca_addr | output | ADDR_W | Address on the bus |

## Verification
A phase toggle that is out of step after reset shows up within two DRAM clocks. `load_phase_o` is then wrong right after release, and every slot comes out one clock late, in swapped order. A slot hold register that reloads on the wrong edge lets the junk the bench drives between load edges reach the bus in the very next core cycle. Stale hold contents after a mid-stream reset appear as non-NOP words within the first two clocks after release. A broken idle encoding is visible on the first empty slot.

// File: rtl/hrcs_pkg.sv
`timescale 1ns/1ps
package hrcs_pkg;
  localparam int CMD_W     = 3;
  localparam int NUM_SLOTS = 2;
  typedef logic [CMD_W-1:0] cmd_t;
  // strobes {ras_n, cas_n, we_n} all high: no operation
  localparam cmd_t CMD_NOP = 3'b111;
endpackage

// File: rtl/hrcs_rst_sync.sv
`timescale 1ns/1ps
module hrcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = STAGES'((sync_q << 1) | STAGES'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hrcs_phase_gen.sv
`timescale 1ns/1ps
module hrcs_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic load_phase
);
  logic beat_q;
  logic beat_d;

  always_comb beat_d = ~beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= 1'b0;
    else        beat_q <= beat_d;
  end

  assign load_phase = ~beat_q;

  assert_phase_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_phase |=> !load_phase);
endmodule

// File: rtl/hrcs_slot_hold.sv
`timescale 1ns/1ps
module hrcs_slot_hold import hrcs_pkg::*; #(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              vld_i,
  input  cmd_t              cmd_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vld_o,
  output cmd_t              cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int REC_W = 1 + CMD_W + BA_W + ADDR_W;

  logic [REC_W-1:0] rec_q;
  logic [REC_W-1:0] rec_d;

  always_comb rec_d = {vld_i, cmd_i, bank_i, addr_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rec_q <= '0;
    else if (load_en) rec_q <= rec_d;
  end

  assign {vld_o, cmd_o, bank_o, addr_o} = rec_q;

  // inputs outside the load edge must leave the held record alone
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(rec_q));
endmodule

// File: rtl/hrcs_beat_mux.sv
`timescale 1ns/1ps
module hrcs_beat_mux import hrcs_pkg::*; #(
  parameter int BA_W          = 3,
  parameter int ADDR_W        = 14,
  parameter bit IDLE_DESELECT = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              second_beat,
  input  logic [NUM_SLOTS-1:0]              vld_i,
  input  logic [NUM_SLOTS-1:0][CMD_W-1:0]   cmd_i,
  input  logic [NUM_SLOTS-1:0][BA_W-1:0]    bank_i,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]  addr_i,
  output logic                              cs_n,
  output cmd_t                              cmd_o,
  output logic [BA_W-1:0]                   bank_o,
  output logic [ADDR_W-1:0]                 addr_o
);
  logic              sel;
  logic              cs_d,   cs_q;
  cmd_t              cmd_d,  cmd_q;
  logic [BA_W-1:0]   bank_d, bank_q;
  logic [ADDR_W-1:0] addr_d, addr_q;

  assign sel = second_beat;

  always_comb begin
    if (vld_i[sel]) begin
      cs_d   = 1'b0;
      cmd_d  = cmd_i[sel];
      bank_d = bank_i[sel];
      addr_d = addr_i[sel];
    end else begin
      cs_d   = IDLE_DESELECT;
      cmd_d  = CMD_NOP;
      bank_d = '0;
      addr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
    end else begin
      cs_q   <= cs_d;
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
    end
  end

  assign cs_n   = cs_q;
  assign cmd_o  = cmd_q;
  assign bank_o = bank_q;
  assign addr_o = addr_q;

  // a deselected bus never carries a command or stray fields
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> (cmd_q == CMD_NOP && bank_q == '0 && addr_q == '0));
endmodule

// File: rtl/hrcs_serializer.sv
`timescale 1ns/1ps
module hrcs_serializer import hrcs_pkg::*; #(
  parameter int BA_W          = 3,
  parameter int ADDR_W        = 14,
  parameter int RST_STAGES    = 2,
  parameter bit IDLE_DESELECT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s0_vld,
  input  logic [2:0]        s0_cmd,
  input  logic [BA_W-1:0]   s0_bank,
  input  logic [ADDR_W-1:0] s0_addr,
  input  logic              s1_vld,
  input  logic [2:0]        s1_cmd,
  input  logic [BA_W-1:0]   s1_bank,
  input  logic [ADDR_W-1:0] s1_addr,
  output logic              load_phase_o,
  output logic              ca_cs_n,
  output logic              ca_ras_n,
  output logic              ca_cas_n,
  output logic              ca_we_n,
  output logic [BA_W-1:0]   ca_bank,
  output logic [ADDR_W-1:0] ca_addr
);
  logic rst_sync_n;
  logic load_phase;

  logic [NUM_SLOTS-1:0]             in_vld,  h_vld;
  logic [NUM_SLOTS-1:0][CMD_W-1:0]  in_cmd,  h_cmd;
  logic [NUM_SLOTS-1:0][BA_W-1:0]   in_bank, h_bank;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] in_addr, h_addr;
  cmd_t bus_cmd;

  assign in_vld  = {s1_vld,  s0_vld};
  assign in_cmd  = {s1_cmd,  s0_cmd};
  assign in_bank = {s1_bank, s0_bank};
  assign in_addr = {s1_addr, s0_addr};

  hrcs_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  hrcs_phase_gen u_phase (
    .clk(clk), .rst_n(rst_sync_n), .load_phase(load_phase));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    hrcs_slot_hold #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_hold (
      .clk(clk), .rst_n(rst_sync_n), .load_en(load_phase),
      .vld_i(in_vld[g]), .cmd_i(in_cmd[g]), .bank_i(in_bank[g]), .addr_i(in_addr[g]),
      .vld_o(h_vld[g]), .cmd_o(h_cmd[g]), .bank_o(h_bank[g]), .addr_o(h_addr[g]));
  end

  hrcs_beat_mux #(.BA_W(BA_W), .ADDR_W(ADDR_W), .IDLE_DESELECT(IDLE_DESELECT)) u_mux (
    .clk(clk), .rst_n(rst_sync_n), .second_beat(load_phase),
    .vld_i(h_vld), .cmd_i(h_cmd), .bank_i(h_bank), .addr_i(h_addr),
    .cs_n(ca_cs_n), .cmd_o(bus_cmd), .bank_o(ca_bank), .addr_o(ca_addr));

  assign {ca_ras_n, ca_cas_n, ca_we_n} = bus_cmd;
  assign load_phase_o = load_phase;

  // edges seen since reset release, so $past never reaches into reset
  logic [2:0] warm_q;
  logic [2:0] warm_d;
  logic       armed;
  always_comb warm_d = (warm_q == 3'd4) ? warm_q : warm_q + 3'd1;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) warm_q <= '0;
    else             warm_q <= warm_d;
  end
  assign armed = (warm_q == 3'd4);

  assert_first_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> load_phase);

  assert_slot0_leads_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && $past(load_phase, 2) && $past(s0_vld, 2)) |->
      (!ca_cs_n && {ca_ras_n, ca_cas_n, ca_we_n} == $past(s0_cmd, 2) &&
       ca_bank == $past(s0_bank, 2) && ca_addr == $past(s0_addr, 2)));

  assert_slot1_trails_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && $past(load_phase, 3) && $past(s1_vld, 3)) |->
      (!ca_cs_n && {ca_ras_n, ca_cas_n, ca_we_n} == $past(s1_cmd, 3) &&
       ca_bank == $past(s1_bank, 3) && ca_addr == $past(s1_addr, 3)));

  assert_empty_slot_nop_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (armed && $past(load_phase, 2) && !$past(s0_vld, 2)) |->
      (ca_cs_n == IDLE_DESELECT && {ca_ras_n, ca_cas_n, ca_we_n} == CMD_NOP));
endmodule

// File: tb/test_hrcs_serializer.sv
`timescale 1ns/1ps
module test_hrcs_serializer;
  localparam int BA_W   = 3;
  localparam int ADDR_W = 14;
  localparam int W      = 4 + BA_W + ADDR_W;

  typedef struct {
    logic              vld;
    logic [2:0]        cmd;
    logic [BA_W-1:0]   bank;
    logic [ADDR_W-1:0] addr;
  } slot_t;
  typedef struct { slot_t a; slot_t b; string tag; } pair_t;
  typedef struct { int due; logic [W-1:0] word; string tag; } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic s0_vld, s1_vld;
  logic [2:0] s0_cmd, s1_cmd;
  logic [BA_W-1:0] s0_bank, s1_bank;
  logic [ADDR_W-1:0] s0_addr, s1_addr;
  logic load_phase_o, ca_cs_n, ca_ras_n, ca_cas_n, ca_we_n;
  logic [BA_W-1:0] ca_bank;
  logic [ADDR_W-1:0] ca_addr;

  hrcs_serializer #(.BA_W(BA_W), .ADDR_W(ADDR_W)) i_hrcs_serializer (
    .clk(clk), .rst_n(rst_n),
    .s0_vld(s0_vld), .s0_cmd(s0_cmd), .s0_bank(s0_bank), .s0_addr(s0_addr),
    .s1_vld(s1_vld), .s1_cmd(s1_cmd), .s1_bank(s1_bank), .s1_addr(s1_addr),
    .load_phase_o(load_phase_o), .ca_cs_n(ca_cs_n), .ca_ras_n(ca_ras_n),
    .ca_cas_n(ca_cas_n), .ca_we_n(ca_we_n), .ca_bank(ca_bank), .ca_addr(ca_addr));

  logic [W-1:0] act_word;
  assign act_word = {ca_cs_n, ca_ras_n, ca_cas_n, ca_we_n, ca_bank, ca_addr};

  localparam logic [W-1:0] DESEL = {1'b1, 3'b111, {BA_W{1'b0}}, {ADDR_W{1'b0}}};
  localparam logic [W-1:0] NOPW  = {1'b0, 3'b111, {BA_W{1'b0}}, {ADDR_W{1'b0}}};

  pair_t stim_q[$];
  exp_t  exp_q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit live = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] enc(slot_t s);
    return s.vld ? {1'b0, s.cmd, s.bank, s.addr} : NOPW;
  endfunction

  function automatic slot_t mk(logic v, logic [2:0] c, int bk, int ad);
    slot_t s;
    s.vld = v; s.cmd = c; s.bank = BA_W'(bk); s.addr = ADDR_W'(ad);
    return s;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver and stream checker, both away from the rising edge
  always @(negedge clk) begin
    while (live && exp_q.size() > 0 && exp_q[0].due < cyc) begin
      checks++; fails++;
      $display("FAIL %s: actual missed expected %h", exp_q[0].tag, exp_q[0].word);
      exp_q.delete(0);
    end
    if (live && exp_q.size() > 0 && exp_q[0].due == cyc) begin
      check(exp_q[0].tag, act_word, exp_q[0].word);
      exp_q.delete(0);
    end
    if (live && load_phase_o) begin
      pair_t p;
      exp_t e;
      if (stim_q.size() > 0) begin
        p = stim_q.pop_front();
        e.due = cyc + 2; e.word = enc(p.a); e.tag = {p.tag, " R3 slot0"}; exp_q.push_back(e);
        e.due = cyc + 3; e.word = enc(p.b); e.tag = {p.tag, " R4 slot1"}; exp_q.push_back(e);
      end else begin
        p.a = mk(1'b0, 3'b000, 0, 0); p.b = p.a;
      end
      {s0_vld, s0_cmd, s0_bank, s0_addr} = {p.a.vld, p.a.cmd, p.a.bank, p.a.addr};
      {s1_vld, s1_cmd, s1_bank, s1_addr} = {p.b.vld, p.b.cmd, p.b.bank, p.b.addr};
    end else if (live) begin
      // R7: junk between load edges must never reach the bus
      {s0_vld, s0_cmd, s0_bank, s0_addr} = {1'b1, 3'(cyc), BA_W'(cyc + 3), ADDR_W'(cyc * 7)};
      {s1_vld, s1_cmd, s1_bank, s1_addr} = {1'b1, 3'(cyc + 1), BA_W'(cyc), ADDR_W'(cyc * 11)};
    end
  end

  task automatic push(slot_t a, slot_t b, string tag);
    pair_t p;
    p.a = a; p.b = b; p.tag = tag;
    stim_q.push_back(p);
  endtask

  task automatic drain();
    while (stim_q.size() > 0 || exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset_release();
    @(posedge clk); #2 rst_n = 1'b1;
    @(posedge clk); @(posedge clk); live = 1'b1;
    @(negedge clk);
    check("R1 deselect until first edge after release", act_word, DESEL);
    check("R2 first clock after release is a load clock", W'(load_phase_o), W'(1));
    @(negedge clk);
    check("R2 phase alternates", W'(load_phase_o), W'(0));
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; live = 1'b0;
    {s0_vld, s0_cmd, s0_bank, s0_addr} = '0;
    {s1_vld, s1_cmd, s1_bank, s1_addr} = '0;
    repeat (3) @(negedge clk);
    check("R1 deselect in reset", act_word, DESEL);
    check("R2 load phase in reset", W'(load_phase_o), W'(1));
    do_reset_release();
  endtask

  task automatic t_act_col();
    push(mk(1, 3'b011, 2, 14'h1a5), mk(1, 3'b101, 2, 14'h040), "R5 act+read");
    push(mk(1, 3'b010, 5, 14'h400), mk(1, 3'b100, 7, 14'h3ff8), "R5 pre+write");
    drain();
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 8; i++)
      push(mk(1, 3'(i), i, 100 + i * 37), mk(1, 3'(7 - i), 7 - i, 9000 - i * 5), "R8 stream");
    drain();
  endtask

  task automatic t_empty_slots();
    push(mk(0, 3'b011, 3, 77), mk(1, 3'b101, 3, 12), "R6 empty slot0");
    push(mk(1, 3'b011, 1, 500), mk(0, 3'b100, 6, 99), "R6 empty slot1");
    push(mk(0, 3'b010, 7, 1), mk(0, 3'b001, 2, 3), "R6 both empty");
    push(mk(1, 3'b111, 4, 21), mk(1, 3'b000, 0, 16383), "R5 extremes");
    drain();
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 3; i++)
      push(mk(1, 3'b011, i, 1000 + i), mk(1, 3'b101, i, 2000 + i), "R9 pre-reset");
    repeat (4) @(negedge clk);
    @(posedge clk); #2 rst_n = 1'b0; live = 1'b0;
    stim_q.delete(); exp_q.delete();
    @(negedge clk);
    check("R9 reset clears bus at once", act_word, DESEL);
    do_reset_release();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 no stale slot after reset", act_word, NOPW);
    end
    push(mk(1, 3'b011, 6, 4321), mk(1, 3'b100, 6, 8), "R9 post-reset");
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_act_col();
    t_back_to_back();
    t_empty_slots();
    t_mid_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule